// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier (163-bit, four bits per step)

This block multiplies two elements of the binary field of degree 163. Each element is a 163-bit vector in polynomial basis, and products are reduced modulo x^163 + x^7 + x^6 + x^3 + 1. The multiplier operand (B) is scanned from its most significant end, four bits per clock. Each step scales the running sum by x^4, reduces it, and adds the digit-selected multiples of the multiplicand (C).

B lives in a 164-bit register whose top bit is a permanent zero, so 41 rotations by four bring it back to its loaded value. In the first step only three of the four digit lanes carry data. Every later step uses all four. Because B is rotated rather than shifted, it is still in place when the product is ready and can be reused. Squaring is done by loading the same value into both operands.

The control pins are plain level signals. A caller loads each operand over the shared `opnd_in` bus with `load_b` or `load_c` while the block is idle. It then raises `start` for one clock and takes `result` in the cycle where `done` is high. The result stays on `result` until the next accepted start. The block has no back-pressure: the product is held for as long as needed.

Top module: `gfm_digit_mul`

## Requirements
- R1: When `done` is high, `result` equals B·C reduced modulo x^163 + x^7 + x^6 + x^3 + 1. Bit i of each vector is the coefficient of x^i.
- R2: Suppose `start` is sampled high at rising edge n while `busy` is low. Then `busy` is high from edge n to edge n+40, and `done` is high only between edges n+40 and n+41. This gives 41 steps per product.
- R3: `done` is high for exactly one cycle per accepted start.
- R4: B is unchanged by a multiplication. A second start, with only C reloaded, multiplies the new C by the earlier B.
- R5: While `busy` is high, `start`, `load_b` and `load_c` have no effect: the running product and both stored operands are unchanged.
- R6: While idle, `result` holds its value until the next accepted start.
- R7: After reset, `busy`, `done` and `result` are all zero.
- R8: A load that is not blocked writes `opnd_in` into B or C. Loading the same value into both gives its square.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_in | input | 163 | Operand value for loading |
| load_b | input | 1 | Write `opnd_in` into B when idle |
| load_c | input | 1 | Write `opnd_in` into C when idle |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 163 | Accumulated product |

## Verification
The assertions assume only that the inputs are synchronous to `clk`. Any of `start`, `load_b` and `load_c` may arrive in any cycle, including during a run. The properties on timing and on the retention of B and of the result therefore must hold whatever the caller does.

The stimulus changes inputs only on falling edges. It deliberately pulses `start` and both loads with unrelated data in the middle of a run, so that the blocking rules are exercised under the same assumptions the assertions make.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} gfm_state_e;

  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/gfm_ctrl.sv
module gfm_ctrl #(
  parameter int unsigned STEPS = 41
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic busy,
  output logic done
);
  import gfm_pkg::*;
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  gfm_state_e state;
  logic [CW-1:0] cnt;

  assign busy    = (state == ST_RUN);
  assign accept  = start && !busy;
  assign step_en = accept || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state <= ST_RUN;
        cnt   <= CW'(1);
      end else if (busy) begin
        if (cnt == LAST) begin
          state <= ST_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gfm_rotreg.sv
module gfm_rotreg #(
  parameter int unsigned W  = 163,
  parameter int unsigned D  = 4,
  parameter int unsigned BW = 164
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  din,
  input  logic          rot,
  output logic [D-1:0]  digit,
  output logic [BW-1:0] q
);
  localparam int unsigned PAD = BW - W;
  logic [BW-1:0] load_val;

  generate
    if (PAD > 0) begin : g_pad
      assign load_val = {{PAD{1'b0}}, din};
    end else begin : g_nopad
      assign load_val = din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (rot)  q <= {q[BW-D-1:0], q[BW-1 -: D]};
  end

  assign digit = q[BW-1 -: D];
endmodule

// File: rtl/gfm_step.sv
module gfm_step #(
  parameter int unsigned W = 163,
  parameter int unsigned D = 4,
  parameter logic [W-1:0] RED = 'hC9
) (
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] c_in,
  input  logic [D-1:0] digit,
  output logic [W-1:0] acc_out
);
  logic [W-1:0] a_sh [D+1];
  logic [W-1:0] c_sh [D];

  assign a_sh[0] = acc_in;
  assign c_sh[0] = c_in;

  for (genvar i = 0; i < D; i++) begin : g_ax
    assign a_sh[i+1] = {a_sh[i][W-2:0], 1'b0} ^ ({W{a_sh[i][W-1]}} & RED);
  end

  for (genvar k = 1; k < D; k++) begin : g_cx
    assign c_sh[k] = {c_sh[k-1][W-2:0], 1'b0} ^ ({W{c_sh[k-1][W-1]}} & RED);
  end

  always_comb begin
    acc_out = a_sh[D];
    for (int k = 0; k < D; k++) begin
      if (digit[k]) acc_out = acc_out ^ c_sh[k];
    end
  end
endmodule

// File: rtl/gfm_digit_mul.sv
module gfm_digit_mul #(
  parameter int unsigned W = 163,
  parameter int unsigned D = 4,
  parameter logic [W-1:0] RED_TAPS = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_in,
  input  logic         load_b,
  input  logic         load_c,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  import gfm_pkg::*;
  localparam int unsigned STEPS = ceil_div(W, D);
  localparam int unsigned BW    = STEPS * D;

  logic          accept, step_en, load_ok;
  logic [D-1:0]  digit;
  logic [BW-1:0] breg_q;
  logic [W-1:0]  creg, acc, acc_src, acc_nxt;

  assign load_ok = !busy && !start;

  gfm_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .step_en(step_en), .busy(busy), .done(done)
  );

  gfm_rotreg #(.W(W), .D(D), .BW(BW)) u_breg (
    .clk(clk), .rst_n(rst_n), .load(load_b && load_ok), .din(opnd_in),
    .rot(step_en), .digit(digit), .q(breg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 creg <= '0;
    else if (load_c && load_ok) creg <= opnd_in;
  end

  assign acc_src = accept ? '0 : acc;

  gfm_step #(.W(W), .D(D), .RED(RED_TAPS)) u_step (
    .acc_in(acc_src), .c_in(creg), .digit(digit), .acc_out(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (step_en) acc <= acc_nxt;
  end

  assign result = acc;
endmodule

// File: rtl/gfm_digit_mul_chk.sv
module gfm_digit_mul_chk #(
  parameter int unsigned W = 163,
  parameter int unsigned STEPS = 41,
  parameter int unsigned BW = 164
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result,
  input logic [BW-1:0] breg_q
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1) + 1;
  logic [CNT_W-1:0] run_cnt;
  logic [BW-1:0]    snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      snap    <= '0;
    end else if (start && !busy) begin
      run_cnt <= CNT_W'(1);
      snap    <= breg_q;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CNT_W'(STEPS)));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_b_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (breg_q == snap));
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind gfm_digit_mul gfm_digit_mul_chk #(.W(W), .STEPS(STEPS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .breg_q(breg_q)
);

// File: tb/tb_gfm_digit_mul.sv
module tb_gfm_digit_mul;
  localparam int W = 163;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opnd_in = '0;
  logic load_b = 1'b0, load_c = 1'b0, start = 1'b0;
  logic busy, done;
  logic [W-1:0] result;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gfm_digit_mul dut (
    .clk(clk), .rst_n(rst_n), .opnd_in(opnd_in), .load_b(load_b),
    .load_c(load_c), .start(start), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] a = '0;
    for (int i = W - 1; i >= 0; i--) begin
      a = {a[W-2:0], 1'b0} ^ (a[W-1] ? 163'hC9 : 163'h0);
      if (b[i]) a = a ^ c;
    end
    return a;
  endfunction

  function automatic logic [W-1:0] rnd();
    return W'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic which_b, input logic [W-1:0] v);
    @(negedge clk);
    opnd_in = v; load_b = which_b; load_c = !which_b;
    @(negedge clk);
    load_b = 1'b0; load_c = 1'b0;
  endtask

  // Starts a run; poke_at >= 0 injects start and both loads with junk in that cycle.
  task automatic run(input string req, input logic [W-1:0] exp, input int poke_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k < 40; k++) begin
      if (k == poke_at) begin
        start = 1'b1; load_b = 1'b1; load_c = 1'b1; opnd_in = rnd();
      end
      @(negedge clk);
      start = 1'b0; load_b = 1'b0; load_c = 1'b0;
    end
    chk({req, " R2 busy before last step"}, W'(busy), W'(1));
    chk({req, " R2 no early done"}, W'(done), W'(0));
    @(negedge clk);
    chk({req, " R2 done on step 41"}, W'(done), W'(1));
    chk({req, " R2 idle at done"}, W'(busy), W'(0));
    chk({req, " R1 product"}, result, exp);
    @(negedge clk);
    chk({req, " R3 single pulse"}, W'(done), W'(0));
    chk({req, " R6 result held"}, result, exp);
  endtask

  task automatic t_reset();
    chk("R7 busy", W'(busy), W'(0));
    chk("R7 done", W'(done), W'(0));
    chk("R7 result", result, '0);
  endtask

  task automatic t_mul(input string req, input logic [W-1:0] b, input logic [W-1:0] c);
    load(1'b1, b);
    load(1'b0, c);
    run(req, ref_mul(b, c), -1);
  endtask

  task automatic t_reduction();
    t_mul("R1 x^162*x", W'(1) << 162, W'(2));
    chk("R1 x^163 reduces to taps", result, 163'hC9);
  endtask

  task automatic t_square();
    logic [W-1:0] v = rnd();
    t_mul("R8 square", v, v);
  endtask

  task automatic t_keep_b();
    logic [W-1:0] b = rnd();
    logic [W-1:0] c2 = rnd();
    t_mul("R4 first", b, rnd());
    load(1'b0, c2);
    run("R4 reuse B", ref_mul(b, c2), -1);
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] b = rnd();
    logic [W-1:0] c = rnd();
    load(1'b1, b);
    load(1'b0, c);
    run("R5 poked run", ref_mul(b, c), 17);
    run("R5 operands untouched", ref_mul(b, c), -1);
  endtask

  task automatic t_hold();
    logic [W-1:0] r = result;
    load(1'b1, rnd());
    load(1'b0, rnd());
    repeat (5) @(negedge clk);
    chk("R6 hold while idle with loads", result, r);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mul("R1 zero", '0, rnd());
    t_mul("R1 one*one", W'(1), W'(1));
    t_mul("R1 identity", W'(1), 163'h5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5);
    t_mul("R1 all ones", '1, '1);
    t_reduction();
    for (int n = 0; n < 6; n++) t_mul("R1 random", rnd(), rnd());
    t_square();
    t_keep_b();
    t_busy_ignore();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule